// File: doc/BRIEF.md
# SPI EEPROM Write Command Controller

This block is the slave-side write path of a small serial EEPROM with a 512-byte array organised in 16-byte pages. It watches the SPI pins (`cs_n`, `sck`, `mosi`) from the system clock domain. It decodes the write opcode, collects the 9-bit start address and the data bytes into a page buffer, and decides whether the write may go ahead. A write is committed only when chip select rises on an exact byte boundary.

Once a write is accepted, a commit engine walks the page buffer twice. The first pass erases every received byte to 0x00 through a simple synchronous memory write port. The second pass programs the buffered values. A hold period of `WRITE_CYCLES` system clocks follows. Throughout this time `wip` is high. In its final cycle the engine pulses `wel_clr` so that the surrounding logic can drop its write enable latch.

The receiver FSM has the states RX_IDLE, RX_OPCODE, RX_ADDR, RX_DATA and RX_SKIP. Its transitions are:
- RX_IDLE goes to RX_OPCODE on a chip-select fall, or to RX_SKIP if a fall comes while busy.
- RX_OPCODE goes to RX_ADDR on a valid opcode, or to RX_SKIP on any other opcode.
- RX_ADDR goes to RX_DATA when the address byte completes.
- Any state returns to RX_IDLE on a chip-select rise.

The commit FSM has the states CM_IDLE, CM_ERASE, CM_PROG and CM_HOLD. It moves CM_IDLE to CM_ERASE on an accepted commit, CM_ERASE to CM_PROG after slot 15, CM_PROG to CM_HOLD after slot 15, and CM_HOLD back to CM_IDLE when the timer expires.

Top module: `spi_eeprom_wr_ctrl`

## Requirements
- R1: The write opcode byte is 0000_X_010, where bit 3 (X) is address bit 8. A transaction whose first byte has any other value writes nothing.
- R2: Bits are taken on rising `sck` edges, most significant bit first. The second byte supplies address bits 7..0.
- R3: A commit happens only when `cs_n` rises with at least one complete data byte received and no partial byte pending. A rise inside a byte, inside the address byte, or before any data byte discards the transaction.
- R4: Data bytes go to consecutive addresses within the page. After slot 15 they wrap to slot 0 of the same page, and a later byte overwrites the earlier one. Bytes of the page that were not received keep their old contents.
- R5: A write is rejected when `wel` is 0 or `wp_n` is 0 at the chip-select rise.
- R6: The `bp` field guards by the addressed page: 00 protects nothing, 01 protects 0x180..0x1FF, 10 protects 0x100..0x1FF, and 11 protects the whole array. A protected write is rejected.
- R7: A transaction whose `cs_n` falls while `wip` is high is ignored entirely.
- R8: For each distinct received byte, the memory port sees exactly two writes. The first write carries 0x00 (erase), and the second carries the data (program).
- R9: After an accepted commit, `wip` is high for exactly 32 + `WRITE_CYCLES` clock cycles. It stays low when no write is accepted.
- R10: `wel_clr` pulses once, in the last cycle of `wip`, only for an accepted write.
- R11: After reset, `wip`, `wel_clr` and `mem_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock |
| mosi | input | 1 | SPI serial data in |
| wp_n | input | 1 | Write protect, low blocks writes |
| bp | input | 2 | Block protect field |
| wel | input | 1 | Write enable latch state |
| wip | output | 1 | Write cycle in progress |
| wel_clr | output | 1 | Pulse to clear the write enable latch |
| mem_we | output | 1 | Memory array write strobe |
| mem_addr | output | 9 | Memory array byte address |
| mem_wdata | output | 8 | Memory array write data |

## Verification
The bench aims at the page wrap with more than 16 bytes. A design that does not wrap would spill into the next page, and one that skips the byte-valid mask would rewrite bytes that were never received.

It also raises chip select one to seven bits into a data byte, inside the address byte, and right after the address. A design that ignored the byte-boundary rule would commit a truncated write.

Further cases cover the protection boundaries just below and at each guarded region, wrong opcodes, and a second transaction started during a busy cycle. In each, a faulty design would alter memory or stretch `wip`. Counting memory strobes and checking that every first write to an address is 0x00 catches a commit engine that skips the erase pass.

// File: rtl/eewr_pkg.sv
package eewr_pkg;
    localparam int EE_DATA_W = 8;
    localparam int EE_ADDR_W = EE_DATA_W + 1;
    localparam logic [2:0] OP_TAIL = 3'b010;

    typedef enum logic [2:0] {
        RX_IDLE, RX_OPCODE, RX_ADDR, RX_DATA, RX_SKIP
    } rx_state_t;

    typedef enum logic [1:0] {
        CM_IDLE, CM_ERASE, CM_PROG, CM_HOLD
    } cm_state_t;
endpackage

// File: rtl/spi_rx_shifter.sv
module spi_rx_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              mosi,
    output logic              cs_fall,
    output logic              cs_rise,
    output logic              on_boundary,
    output logic              byte_stb,
    output logic [BYTE_W-1:0] byte_val
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    logic [2:0]        cs_s, sck_s;
    logic [1:0]        mosi_s;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] sh_q;
    logic              sck_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_s   <= 3'b111;
            sck_s  <= 3'b000;
            mosi_s <= 2'b00;
        end else begin
            cs_s   <= {cs_s[1:0], cs_n};
            sck_s  <= {sck_s[1:0], sck};
            mosi_s <= {mosi_s[0], mosi};
        end
    end

    assign cs_fall     = cs_s[2] & ~cs_s[1];
    assign cs_rise     = ~cs_s[2] & cs_s[1];
    assign sck_rise    = ~sck_s[2] & sck_s[1];
    assign on_boundary = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            sh_q     <= '0;
            byte_stb <= 1'b0;
            byte_val <= '0;
        end else begin
            byte_stb <= 1'b0;
            if (cs_s[1]) begin
                cnt_q <= '0;
            end else if (sck_rise) begin
                sh_q  <= {sh_q[BYTE_W-2:0], mosi_s[1]};
                cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
                if (cnt_q == LAST) begin
                    byte_stb <= 1'b1;
                    byte_val <= {sh_q[BYTE_W-2:0], mosi_s[1]};
                end
            end
        end
    end
endmodule

// File: rtl/page_buffer.sv
module page_buffer #(
    parameter int PAGE_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PAGE_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int SLOTS = 1 << PAGE_W;

    logic [DATA_W-1:0] slot_q [SLOTS];
    logic [SLOTS-1:0]  valid_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < SLOTS; i++) slot_q[i] <= '0;
        end else if (clr) begin
            valid_q <= '0;
        end else if (wr_en) begin
            slot_q[wr_idx]  <= wr_data;
            valid_q[wr_idx] <= 1'b1;
        end
    end

    assign rd_data  = slot_q[rd_idx];
    assign rd_valid = valid_q[rd_idx];
endmodule

// File: rtl/protect_check.sv
module protect_check #(
    parameter int ADDR_W = 9
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        bp,
    input  logic              wp_n,
    input  logic              wel,
    input  logic              busy,
    output logic              ok
);
    logic guarded;

    always_comb begin
        unique case (bp)
            2'b00:   guarded = 1'b0;
            2'b01:   guarded = &addr[ADDR_W-1:ADDR_W-2];
            2'b10:   guarded = addr[ADDR_W-1];
            default: guarded = 1'b1;
        endcase
        ok = wel && wp_n && !busy && !guarded;
    end
endmodule

// File: rtl/spi_eeprom_wr_ctrl.sv
module spi_eeprom_wr_ctrl
    import eewr_pkg::*;
#(
    parameter int PAGE_W       = 4,
    parameter int WRITE_CYCLES = 40
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 sck,
    input  logic                 mosi,
    input  logic                 wp_n,
    input  logic [1:0]           bp,
    input  logic                 wel,
    output logic                 wip,
    output logic                 wel_clr,
    output logic                 mem_we,
    output logic [EE_ADDR_W-1:0] mem_addr,
    output logic [EE_DATA_W-1:0] mem_wdata
);
    localparam int TMR_W = (WRITE_CYCLES > 1) ? $clog2(WRITE_CYCLES) : 1;
    localparam logic [PAGE_W-1:0] LAST_IDX = '1;
    localparam logic [TMR_W-1:0]  LAST_TMR = TMR_W'(WRITE_CYCLES - 1);

    rx_state_t rx_st, rx_nx;
    cm_state_t cm_st, cm_nx;

    logic                 cs_fall, cs_rise, on_boundary, byte_stb;
    logic [EE_DATA_W-1:0] byte_val;
    logic [EE_ADDR_W-1:0] addr_q;
    logic [PAGE_W-1:0]    ptr_q, idx_q;
    logic [TMR_W-1:0]     tmr_q;
    logic                 got_q, busy, acc_ok, op_ok, go;
    logic [EE_DATA_W-1:0] buf_rd;
    logic                 buf_valid, buf_clr, buf_wr;

    spi_rx_shifter #(.BYTE_W(EE_DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .cs_fall(cs_fall), .cs_rise(cs_rise), .on_boundary(on_boundary),
        .byte_stb(byte_stb), .byte_val(byte_val)
    );

    page_buffer #(.PAGE_W(PAGE_W), .DATA_W(EE_DATA_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr_en(buf_wr),
        .wr_idx(ptr_q), .wr_data(byte_val), .rd_idx(idx_q),
        .rd_data(buf_rd), .rd_valid(buf_valid)
    );

    protect_check #(.ADDR_W(EE_ADDR_W)) u_prot (
        .addr(addr_q), .bp(bp), .wp_n(wp_n), .wel(wel), .busy(busy), .ok(acc_ok)
    );

    assign busy    = (cm_st != CM_IDLE);
    assign op_ok   = (byte_val[7:4] == 4'b0000) && (byte_val[2:0] == OP_TAIL);
    assign go      = (rx_st == RX_DATA) && cs_rise && got_q && on_boundary && acc_ok;
    assign buf_clr = (rx_st == RX_IDLE) && cs_fall && !busy;
    assign buf_wr  = (rx_st == RX_DATA) && byte_stb;

    // state registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_st <= RX_IDLE;
            cm_st <= CM_IDLE;
        end else begin
            rx_st <= rx_nx;
            cm_st <= cm_nx;
        end
    end

    // receiver transitions
    always_comb begin
        rx_nx = rx_st;
        unique case (rx_st)
            RX_IDLE:   if (cs_fall) rx_nx = busy ? RX_SKIP : RX_OPCODE;
            RX_OPCODE: if (cs_rise) rx_nx = RX_IDLE;
                       else if (byte_stb) rx_nx = op_ok ? RX_ADDR : RX_SKIP;
            RX_ADDR:   if (cs_rise) rx_nx = RX_IDLE;
                       else if (byte_stb) rx_nx = RX_DATA;
            RX_DATA:   if (cs_rise) rx_nx = RX_IDLE;
            RX_SKIP:   if (cs_rise) rx_nx = RX_IDLE;
            default:   rx_nx = RX_IDLE;
        endcase
    end

    // commit transitions
    always_comb begin
        cm_nx = cm_st;
        unique case (cm_st)
            CM_IDLE:  if (go) cm_nx = CM_ERASE;
            CM_ERASE: if (idx_q == LAST_IDX) cm_nx = CM_PROG;
            CM_PROG:  if (idx_q == LAST_IDX) cm_nx = CM_HOLD;
            CM_HOLD:  if (tmr_q == LAST_TMR) cm_nx = CM_IDLE;
            default:  cm_nx = CM_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            ptr_q  <= '0;
            got_q  <= 1'b0;
            idx_q  <= '0;
            tmr_q  <= '0;
        end else begin
            if (rx_st == RX_OPCODE && byte_stb)
                addr_q[EE_ADDR_W-1] <= byte_val[3];
            if (rx_st == RX_ADDR && byte_stb) begin
                addr_q[EE_DATA_W-1:0] <= byte_val;
                ptr_q <= byte_val[PAGE_W-1:0];
                got_q <= 1'b0;
            end
            if (buf_wr) begin
                ptr_q <= ptr_q + 1'b1;
                got_q <= 1'b1;
            end
            if (cm_st == CM_ERASE || cm_st == CM_PROG) idx_q <= idx_q + 1'b1;
            else idx_q <= '0;
            if (cm_st == CM_HOLD) tmr_q <= tmr_q + 1'b1;
            else tmr_q <= '0;
        end
    end

    // outputs
    always_comb begin
        wip       = busy;
        wel_clr   = (cm_st == CM_HOLD) && (tmr_q == LAST_TMR);
        mem_we    = (cm_st == CM_ERASE || cm_st == CM_PROG) && buf_valid;
        mem_addr  = {addr_q[EE_ADDR_W-1:PAGE_W], idx_q};
        mem_wdata = (cm_st == CM_PROG) ? buf_rd : '0;
    end
endmodule

// File: rtl/eewr_checker.sv
module eewr_checker #(
    parameter int ADDR_W = 9,
    parameter int PAGE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wp_n,
    input logic [1:0]        bp,
    input logic              wel,
    input logic              wip,
    input logic              wel_clr,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr
);
    assert_we_in_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wip);

    assert_clr_in_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr |-> wip);

    assert_clr_ends_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr |=> !wip);

    assert_start_needs_enables_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> (wel && wp_n));

    assert_full_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (bp != 2'b11));

    assert_single_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we) && $past(wip))
            |-> (mem_addr[ADDR_W-1:PAGE_W] == $past(mem_addr[ADDR_W-1:PAGE_W])));
endmodule

bind spi_eeprom_wr_ctrl eewr_checker #(.ADDR_W(eewr_pkg::EE_ADDR_W), .PAGE_W(PAGE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .bp(bp), .wel(wel), .wip(wip),
    .wel_clr(wel_clr), .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/sim_spi_eeprom_wr_ctrl.sv
module sim_spi_eeprom_wr_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WC = 40;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, wp_n = 1'b1, wel = 1'b1;
    logic [1:0] bp = 2'b00;
    logic       wip, wel_clr, mem_we;
    logic [8:0] mem_addr;
    logic [7:0] mem_wdata;

    int checks = 0, failures = 0;
    int wip_cycles = 0, we_count = 0, erase_err = 0, clr_count = 0;
    bit hold_wel = 1'b0;
    logic [7:0] dut_mem [512];
    logic [7:0] exp_mem [512];
    bit         touched [512];
    logic [7:0] txd [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_eeprom_wr_ctrl #(.PAGE_W(4), .WRITE_CYCLES(WC)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .wp_n(wp_n), .bp(bp), .wel(wel), .wip(wip), .wel_clr(wel_clr),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    // port monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (wip) wip_cycles++;
            if (mem_we) begin
                we_count++;
                if (!touched[mem_addr] && mem_wdata != 8'h00) erase_err++;
                touched[mem_addr] = 1'b1;
                dut_mem[mem_addr] = mem_wdata;
            end
            if (wel_clr) begin
                clr_count++;
                if (!hold_wel) wel = 1'b0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic spi_bit(input logic b);
        @(negedge clk); mosi = b;
        repeat (4) @(negedge clk); sck = 1'b1;
        repeat (4) @(negedge clk); sck = 1'b0;
    endtask

    task automatic spi_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) spi_bit(b[i]);
    endtask

    // cut: 0 full, 1 stop inside address byte
    task automatic send_txn(input logic [7:0] opc, input logic [7:0] alow, input int n,
                            input int tail, input bit cut);
        cs_n = 1'b0;
        repeat (6) @(negedge clk);
        spi_byte(opc);
        if (cut) begin
            for (int i = 7; i >= 5; i--) spi_bit(alow[i]);
        end else begin
            spi_byte(alow);
            for (int k = 0; k < n; k++) spi_byte(txd[k]);
            for (int t = 0; t < tail; t++) spi_bit(1'b1);
        end
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    function automatic bit guarded(input logic [1:0] b, input logic [8:0] a);
        case (b)
            2'b00:   return 1'b0;
            2'b01:   return a >= 9'h180;
            2'b10:   return a >= 9'h100;
            default: return 1'b1;
        endcase
    endfunction

    function automatic int distinct(input int n);
        return (n > 16) ? 16 : n;
    endfunction

    task automatic clear_monitor();
        wip_cycles = 0; we_count = 0; erase_err = 0; clr_count = 0;
        for (int i = 0; i < 512; i++) touched[i] = 1'b0;
    endtask

    task automatic apply_model(input logic [8:0] a, input int n);
        for (int k = 0; k < n; k++) begin
            logic [3:0] s;
            s = a[3:0] + 4'(k);
            exp_mem[{a[8:4], s}] = txd[k];
        end
    endtask

    task automatic compare_mem(input string req);
        int bad = 0, first = -1;
        for (int i = 0; i < 512; i++)
            if (dut_mem[i] !== exp_mem[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        if (first < 0) check(1'b1, req, "memory", 0, 0);
        else check(1'b0, req, $sformatf("memory mismatches=%0d at addr %0d", bad, first),
                   int'(dut_mem[first]), int'(exp_mem[first]));
    endtask

    task automatic run_case(input string req, input logic [8:0] a, input int n, input int tail,
                            input bit cut, input bit bad_op);
        logic [7:0] opc;
        bit exp_ok;
        logic wel_before;
        clear_monitor();
        opc = bad_op ? {4'b0001, a[8], 3'b010} : {4'b0000, a[8], 3'b010};
        exp_ok = !bad_op && !cut && n >= 1 && tail == 0 && wel && wp_n && !guarded(bp, a);
        wel_before = wel;
        send_txn(opc, a[7:0], n, tail, cut);
        repeat (WC + 50) @(negedge clk);
        if (exp_ok) apply_model(a, n);
        compare_mem(req);
        check(wip_cycles == (exp_ok ? 32 + WC : 0), "R9", {req, " wip length"}, wip_cycles, exp_ok ? 32 + WC : 0);
        check(we_count == (exp_ok ? 2 * distinct(n) : 0), "R8", {req, " write strobes"}, we_count, exp_ok ? 2 * distinct(n) : 0);
        check(erase_err == 0, "R8", {req, " erase first"}, erase_err, 0);
        check(clr_count == (exp_ok ? 1 : 0), "R10", {req, " wel_clr pulses"}, clr_count, exp_ok ? 1 : 0);
        check(wel == (exp_ok ? 1'b0 : wel_before), "R10", {req, " wel after"}, int'(wel), exp_ok ? 0 : int'(wel_before));
    endtask

    task automatic fill(input int n, input int base);
        for (int k = 0; k < n; k++) txd[k] = 8'(base + 7 * k + 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 512; i++) begin
            dut_mem[i] = 8'hA5;
            exp_mem[i] = 8'hA5;
        end
        repeat (3) @(negedge clk);
        check(wip == 1'b0 && wel_clr == 1'b0 && mem_we == 1'b0, "R11", "outputs in reset",
              int'({wip, wel_clr, mem_we}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(wip == 1'b0 && mem_we == 1'b0, "R11", "outputs after reset", int'({wip, mem_we}), 0);

        // R2: single byte write, low page
        wel = 1'b1; fill(1, 8'h3C); run_case("R2 byte write", 9'h023, 1, 0, 1'b0, 1'b0);
        // R1 / R2: A8 carried in opcode bit 3
        wel = 1'b1; fill(3, 8'h51); run_case("R1 upper half address", 9'h1C5, 3, 0, 1'b0, 1'b0);
        // R1: wrong opcode ignored
        wel = 1'b1; fill(2, 8'h11); run_case("R1 bad opcode", 9'h040, 2, 0, 1'b0, 1'b1);
        // R4: page wrap with overwrite, 20 bytes from slot 14
        wel = 1'b1; fill(20, 8'h80); run_case("R4 page wrap", 9'h0AE, 20, 0, 1'b0, 1'b0);
        // R3: partial byte, cut address, no data byte
        wel = 1'b1; fill(2, 8'h22); run_case("R3 partial byte", 9'h060, 2, 3, 1'b0, 1'b0);
        wel = 1'b1; fill(2, 8'h22); run_case("R3 seven extra bits", 9'h061, 1, 7, 1'b0, 1'b0);
        wel = 1'b1; run_case("R3 rise in address", 9'h070, 0, 0, 1'b1, 1'b0);
        wel = 1'b1; run_case("R3 no data byte", 9'h071, 0, 0, 1'b0, 1'b0);
        // R5
        wel = 1'b0; fill(1, 8'h44); run_case("R5 latch clear", 9'h080, 1, 0, 1'b0, 1'b0);
        wel = 1'b1; wp_n = 1'b0; run_case("R5 write protect", 9'h081, 1, 0, 1'b0, 1'b0);
        wp_n = 1'b1;
        // R6 protection boundaries
        bp = 2'b01; wel = 1'b1; fill(2, 8'h61); run_case("R6 bp01 below", 9'h17E, 2, 0, 1'b0, 1'b0);
        wel = 1'b1; run_case("R6 bp01 guarded", 9'h180, 2, 0, 1'b0, 1'b0);
        bp = 2'b10; wel = 1'b1; run_case("R6 bp10 below", 9'h0F0, 2, 0, 1'b0, 1'b0);
        wel = 1'b1; run_case("R6 bp10 guarded", 9'h100, 2, 0, 1'b0, 1'b0);
        bp = 2'b11; wel = 1'b1; run_case("R6 bp11 guarded", 9'h000, 2, 0, 1'b0, 1'b0);
        bp = 2'b00;

        // R7: second transaction starts while busy
        clear_monitor();
        wel = 1'b1; hold_wel = 1'b1;
        fill(3, 8'h90);
        send_txn(8'h02, 8'h30, 3, 0, 1'b0);
        apply_model(9'h030, 3);
        fill(2, 8'hC0);
        send_txn(8'h02, 8'h50, 2, 0, 1'b0);
        repeat (WC + 50) @(negedge clk);
        compare_mem("R7 busy ignore");
        check(wip_cycles == 32 + WC, "R7", "wip length busy case", wip_cycles, 32 + WC);
        check(we_count == 6, "R7", "write strobes busy case", we_count, 6);
        hold_wel = 1'b0;

        // constrained random mix
        void'($urandom(32'd20240611));
        for (int it = 0; it < 40; it++) begin
            logic [8:0] a;
            int n, tail;
            bit bad;
            a    = 9'($urandom % 512);
            n    = 1 + int'($urandom % 20);
            bp   = 2'($urandom % 4);
            wp_n = ($urandom % 6) != 0;
            wel  = ($urandom % 4) != 0;
            tail = ($urandom % 6 == 0) ? 1 + int'($urandom % 7) : 0;
            bad  = ($urandom % 10 == 0);
            for (int k = 0; k < n; k++) txd[k] = 8'($urandom);
            run_case("R4 random", a, n, tail, 1'b0, bad);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule